// File: doc/BRIEF.md
# Two-Digit Decimal Scan Display Driver

This block shows a 4-bit binary value as a two-digit decimal number, 00 through 15, on a pair of seven-segment displays that share a single set of segment lines. A combinational splitter turns the value into a tens digit and a ones digit. A free-running phase counter produces a square wave that spends a fixed number of clocks on each digit. That same square wave selects which digit goes into the segment decoder, and it is also the display-enable output that lights the matching display.

With the default 50 MHz clock, each digit is lit for 8 ms (400,000 cycles) and then the other digit is lit. A full cycle over both digits therefore takes 16 ms, which is fast enough that both digits appear lit at once. The tens digit is always shown, so single-digit values appear with a leading zero. The half-period length is a parameter, so a short value can be used for simulation. A second parameter inverts every segment line for common-anode displays.

Top module: `dsd_scan_top`

## Requirements
- R1: While `tens_en_o` is 0, `seg_o` shows the ones digit. The ones digit is `value_i` minus 10 when `value_i` is 10 or more, and `value_i` otherwise.
- R2: While `tens_en_o` is 1, `seg_o` shows the tens digit. The tens digit is 1 when `value_i` is 10 or more, and 0 otherwise. A tens digit of 0 is still displayed.
- R3: After each toggle, `tens_en_o` holds its level for exactly HALF_CYCLES clocks and then inverts, so one full cycle over both digits is 2*HALF_CYCLES clocks.
- R4: A synchronous reset (`rst_i` high at a rising edge) clears the phase counter and drives `tens_en_o` to 0, so the ones digit is shown first. The first toggle after reset is released comes HALF_CYCLES rising edges later.
- R5: Segment bit 0 is segment a, and bits 1 to 6 are segments b to g in order. With active-high polarity, digits 0 to 9 give the patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R6: `seg_o` follows a change of `value_i` in the same cycle, with no register between the input and the segment lines.
- R7: With SEG_ACTIVE_LOW = 1, every segment line is the inverse of its active-high value. `tens_en_o` is not affected by this parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (50 MHz for the default half-period) |
| rst_i | input | 1 | Synchronous reset, active high |
| value_i | input | 4 | Binary value to display, 0 to 15 |
| seg_o | output | 7 | Segment lines a (bit 0) to g (bit 6) |
| tens_en_o | output | 1 | Display select: 1 enables the tens display, 0 enables the ones display |

## Verification
Two things can happen in the same cycle: the phase toggle that switches digits, and a change of the input value. If they coincide, the segments must show the new value's digit for the new phase right away. The bench changes `value_i` to a random code on every clock over many half-periods, so changes fall on toggle edges as well as between them. It also sweeps each code for a full cycle over both digits. It asserts reset both in the middle of the tens phase and on a toggle edge. A behavioural model judges every cycle: it counts edges since reset and derives the phase with a division, and it works out the digits with division and remainder by ten.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
   localparam int DIGIT_W = 4;
   localparam int SEG_W   = 7;
   localparam int RADIX   = 10;

   typedef logic [DIGIT_W-1:0] digit_t;
   typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/dsd_split.sv
// Binary 0..15 to tens/ones decimal digits: one compare, one subtract.
module dsd_split
   import dsd_pkg::*;
(
   input  logic [DIGIT_W-1:0] value_i,
   output logic [DIGIT_W-1:0] tens_o,
   output logic [DIGIT_W-1:0] ones_o
);
   localparam digit_t RADIX_D = digit_t'(RADIX);

   logic over_nine;

   always_comb begin
      over_nine = (value_i >= RADIX_D);
      tens_o    = {{(DIGIT_W-1){1'b0}}, over_nine};
      ones_o    = over_nine ? (value_i - RADIX_D) : value_i;
   end
endmodule

// File: rtl/dsd_refresh.sv
// Phase generator: square wave holding each level for HALF_CYCLES clocks.
module dsd_refresh #(
   parameter int  HALF_CYCLES = 400000,
   localparam int CNT_W       = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic             phase_o,
   output logic [CNT_W-1:0] count_o
);
   if (HALF_CYCLES < 2) begin : g_bad_half
      $error("dsd_refresh: HALF_CYCLES must be at least 2");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             phase_q;
   logic             wrap;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (wrap) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign phase_o = phase_q;
   assign count_o = cnt_q;
endmodule

// File: rtl/dsd_seg_dec.sv
// Decimal digit to seven segments, bit 0 = a .. bit 6 = g.
module dsd_seg_dec
   import dsd_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [DIGIT_W-1:0] digit_i,
   output logic [SEG_W-1:0]   seg_o
);
   if (SEG_W != 7) begin : g_bad_seg
      $error("dsd_seg_dec: segment width must be 7");
   end

   seg_t lit;

   always_comb begin
      case (digit_i)
         4'd0:    lit = 7'h3F;
         4'd1:    lit = 7'h06;
         4'd2:    lit = 7'h5B;
         4'd3:    lit = 7'h4F;
         4'd4:    lit = 7'h66;
         4'd5:    lit = 7'h6D;
         4'd6:    lit = 7'h7D;
         4'd7:    lit = 7'h07;
         4'd8:    lit = 7'h7F;
         4'd9:    lit = 7'h6F;
         default: lit = 7'h00;
      endcase
   end

   if (ACTIVE_LOW) begin : g_common_anode
      assign seg_o = ~lit;
   end else begin : g_common_cathode
      assign seg_o = lit;
   end
endmodule

// File: rtl/dsd_scan_top.sv
module dsd_scan_top #(
   parameter int HALF_CYCLES    = 400000,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [3:0] value_i,
   output logic [6:0] seg_o,
   output logic       tens_en_o
);
   localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

   logic [3:0]       tens_d;
   logic [3:0]       ones_d;
   logic [3:0]       shown_d;
   logic             phase;
   logic [CNT_W-1:0] phase_cnt;

   dsd_split u_split (
      .value_i (value_i),
      .tens_o  (tens_d),
      .ones_o  (ones_d)
   );

   dsd_refresh #(.HALF_CYCLES(HALF_CYCLES)) u_refresh (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .phase_o (phase),
      .count_o (phase_cnt)
   );

   // The same phase bit picks the digit and enables the matching display.
   always_comb shown_d = phase ? tens_d : ones_d;

   dsd_seg_dec #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_dec (
      .digit_i (shown_d),
      .seg_o   (seg_o)
   );

   assign tens_en_o = phase;
endmodule

// File: rtl/dsd_scan_chk.sv
module dsd_scan_chk #(
   parameter int HALF_CYCLES    = 400000,
   parameter bit SEG_ACTIVE_LOW = 1'b0,
   parameter int CNT_W          = 19
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic [3:0]       value_i,
   input logic [6:0]       seg_o,
   input logic             tens_en_o,
   input logic [CNT_W-1:0] phase_cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

   logic [6:0] lit;
   assign lit = SEG_ACTIVE_LOW ? ~seg_o : seg_o;

   // R4: a reset edge leaves the ones phase with the counter cleared
   p_reset_clear_r4: assert property (@(posedge clk_i)
      rst_i |=> (!tens_en_o && phase_cnt == '0));

   // R3: level held while the count is short of the end
   p_hold_level_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_cnt != LAST) |=> $stable(tens_en_o));

   // R3: level flips when the count ends
   p_flip_level_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_cnt == LAST) |=> (tens_en_o != $past(tens_en_o)));

   // R3: counter stays inside one half-period
   p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      phase_cnt <= LAST);

   // R2: tens phase shows a 0 below ten, including the leading zero
   p_tens_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (tens_en_o && value_i < 4'd10) |-> (lit == 7'h3F));

   // R2: tens phase shows a 1 from ten up
   p_tens_one_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (tens_en_o && value_i >= 4'd10) |-> (lit == 7'h06));

   // R5: every displayed digit lights at least two segments
   p_never_dark_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(lit) >= 2);
endmodule

bind dsd_scan_top dsd_scan_chk #(
   .HALF_CYCLES    (HALF_CYCLES),
   .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW),
   .CNT_W          (CNT_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .value_i   (value_i),
   .seg_o     (seg_o),
   .tens_en_o (tens_en_o),
   .phase_cnt (phase_cnt)
);

// File: tb/dsd_scan_top_test.sv
module dsd_scan_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] val = 4'd0;
   logic [6:0] seg, seg_n;
   logic       sel, sel_n;

   int  checks = 0;
   int  fails  = 0;
   int  cyc    = 0;
   bit  armed  = 1'b0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsd_scan_top #(.HALF_CYCLES(HALF), .SEG_ACTIVE_LOW(1'b0)) uut (
      .clk_i(clk), .rst_i(rst), .value_i(val), .seg_o(seg), .tens_en_o(sel));

   dsd_scan_top #(.HALF_CYCLES(HALF), .SEG_ACTIVE_LOW(1'b1)) uut_inv (
      .clk_i(clk), .rst_i(rst), .value_i(val), .seg_o(seg_n), .tens_en_o(sel_n));

   // R5 patterns, bit 0 = a
   function automatic logic [6:0] pattern(input int d);
      case (d)
         0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
         4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
         8: return 7'h7F;  9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h (cycle %0d, value %0d)",
                  tag, what, act, exp, cyc, val);
      end
   endtask

   task automatic compare();
      logic       exp_sel;
      int         digit;
      logic [6:0] exp_seg;
      exp_sel = ((cyc / HALF) % 2) == 1;
      digit   = exp_sel ? (int'(val) / 10) : (int'(val) % 10);
      exp_seg = pattern(digit);
      if (cyc == 0) check("R4", "select after reset", {6'd0, sel}, 7'd0);
      else          check("R3", "select", {6'd0, sel}, {6'd0, exp_sel});
      if (exp_sel) check("R2,R5", "tens segments", seg, exp_seg);
      else         check("R1,R5", "ones segments", seg, exp_seg);
      check("R7", "inverted segments", seg_n, ~exp_seg);
      check("R7", "inverted variant select", {6'd0, sel_n}, {6'd0, exp_sel});
   endtask

   // Drive at the falling edge, check combinationally (R6), clock, check again.
   task automatic step(input logic [3:0] nv, input logic nr);
      val = nv;
      rst = nr;
      #1;
      if (armed) compare();   // R6: new value visible before any edge
      @(posedge clk);
      if (rst) begin cyc = 0; armed = 1'b1; end
      else if (armed) cyc++;
      @(negedge clk);
      if (armed) compare();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R4: reset held for a few edges
      for (int i = 0; i < 3; i++) step(4'd7, 1'b1);
      // R1 R2 R3: each code held for one full two-digit cycle plus one
      for (int v = 0; v < 16; v++)
         for (int k = 0; k < 2*HALF + 1; k++) step(4'(v), 1'b0);
      // R4: reset in the middle of the tens phase
      while (!(((cyc / HALF) % 2) == 1 && (cyc % HALF) == 2)) step(4'd12, 1'b0);
      step(4'd12, 1'b1);
      for (int k = 0; k < 2*HALF + 2; k++) step(4'd13, 1'b0);
      // R4: reset on the edge where a toggle would happen
      while ((cyc % HALF) != HALF - 1) step(4'd4, 1'b0);
      step(4'd15, 1'b1);
      for (int k = 0; k < HALF + 1; k++) step(4'd15, 1'b0);
      // R6 with R3: value changes every clock, including on toggle edges
      for (int k = 0; k < 400; k++) step(4'($urandom_range(15)), 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule